// File: doc/BRIEF.md
# Program-Flow Trace Capture

This block sits beside a processor core's retire stage and records selected program-counter values into a small circular trace memory. The core reports each retire-side event as a one-cycle strobe with its addresses: an issued execution set, a set holding a change-of-flow (COF) instruction, a MARK instruction, a hardware-loop back-edge, and an interrupt entry. A six-bit control register selects which kinds of event are recorded. A global enable bit gates all capture. Software can write that bit, and two hardware trigger strobes can set or clear it.

Every recorded item is a 32-bit address with a 3-bit type tag. Some events produce two items. These are a COF set, an interrupt entry and a back-edge of a long loop. The first item goes to the trace memory in the event's own cycle, and the second waits in a small staging queue. When the queue is close to full, the block raises a stall request so that the core holds back further events. A debugger drains the memory through a pop-style read port, and a flush strobe resets the read side.

Top module: `flow_trace_unit`

## Requirements
- R1: Software writes the control register with `cfg_we`/`cfg_wdata`, and `cfg_q` reads it back. The bit positions are: bit0 COF tracing, bit1 interrupt tracing, bit2 execution-set tracing, bit3 MARK tracing, bit4 global enable, bit5 loop tracing. Reset clears all six bits.
- R2: A `trig_on` pulse sets the global enable and a `trig_off` pulse clears it. If both arrive in the same cycle, `trig_off` wins. Neither trigger changes the mode bits.
- R3: While the global enable is clear, no event of any kind creates an entry, whatever the mode bits hold.
- R4: With COF tracing on, a `set_has_cof` strobe creates two entries. The first is `set_pc` with tag 0 and the second is `cof_dest` with tag 1.
- R5: With interrupt tracing on, an `irq_take` strobe creates two entries. The first is `irq_from_pc` with tag 2 and the second is `irq_vector` with tag 3.
- R6: With loop tracing on, a `loop_edge` strobe whose `loop_count` exceeds 1 creates `loop_end_pc` with tag 4. When `loop_long` is high, it also creates `loop_start_pc` with tag 5, after the tag-4 entry. A `loop_count` of 0 or 1 marks the final pass, which creates nothing. A loop of N passes therefore yields N-1 captures.
- R7: With MARK tracing on, `mark_hit` creates a single entry, `set_pc` with tag 6. With execution-set tracing on, each `set_issue` creates a single entry, `set_pc` with tag 7.
- R8: At most one event is accepted per cycle. When several enabled events strobe together, only the highest-ranked one is recorded, in the order interrupt, COF, loop, MARK, execution set.
- R9: A second entry reaches the trace memory one or more cycles after the first, and entries keep their order. `stall_req` is high while the staging queue holds QDEPTH-1 or more entries. Any event presented while `stall_req` is high is ignored.
- R10: The trace memory holds DEPTH entries. When it is full, a new entry replaces the oldest one and `buf_level` stays at DEPTH. `wrapped` rises on the first replacement and stays set.
- R11: A `rd_flush` pulse empties the trace memory, which sets `buf_level` to 0 and `rd_valid` low, and clears `wrapped`. Later entries are read back normally.
- R12: `rd_valid` is high exactly when the memory is non-empty. At that time `rd_tag`/`rd_addr` show the oldest entry, and `rd_en` removes it, so entries leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 6 | Control register write value |
| cfg_q | output | 6 | Control register contents |
| trig_on | input | 1 | Hardware trigger that sets the global enable |
| trig_off | input | 1 | Hardware trigger that clears the global enable |
| set_issue | input | 1 | An execution set was issued |
| set_has_cof | input | 1 | The retiring set holds a change-of-flow instruction |
| mark_hit | input | 1 | A MARK instruction executed |
| set_pc | input | 32 | Address of the first instruction of the current set |
| cof_dest | input | 32 | Change-of-flow target address |
| loop_edge | input | 1 | Hardware loop reached its end address |
| loop_long | input | 1 | The loop is a long loop |
| loop_count | input | 16 | Loop counter value at the loop end |
| loop_end_pc | input | 32 | Loop last address |
| loop_start_pc | input | 32 | Loop start address |
| irq_take | input | 1 | An interrupt is being serviced |
| irq_from_pc | input | 32 | Last set executed or aborted before the interrupt |
| irq_vector | input | 32 | Interrupt vector address |
| stall_req | output | 1 | Core must hold trace events |
| rd_en | input | 1 | Pop the oldest trace entry |
| rd_flush | input | 1 | Empty the trace memory and clear the wrap flag |
| rd_valid | output | 1 | Trace memory is non-empty |
| rd_tag | output | 3 | Type tag of the oldest entry |
| rd_addr | output | 32 | Address of the oldest entry |
| buf_level | output | 5 | Number of stored entries |
| wrapped | output | 1 | An entry has been overwritten since the last flush |

## Verification
The bench sets DEPTH to 8 in place of the default 16. The other parameters keep their defaults: QDEPTH 4, PCW 32 and LCW 16. The smaller memory lets ten MARK entries overrun it, which exercises oldest-entry replacement, the saturated level and the wrap flag at low cost. A queue depth of four lets three back-to-back COF events raise the stall request, and a fourth event arriving during the stall then shows that it is dropped.

// File: rtl/flow_trace_unit.sv
module flow_trace_unit #(
  parameter int PCW    = 32,
  parameter int DEPTH  = 16,
  parameter int QDEPTH = 4,
  parameter int LCW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [5:0]               cfg_wdata,
  output logic [5:0]               cfg_q,
  input  logic                     trig_on,
  input  logic                     trig_off,
  input  logic                     set_issue,
  input  logic                     set_has_cof,
  input  logic                     mark_hit,
  input  logic [PCW-1:0]           set_pc,
  input  logic [PCW-1:0]           cof_dest,
  input  logic                     loop_edge,
  input  logic                     loop_long,
  input  logic [LCW-1:0]           loop_count,
  input  logic [PCW-1:0]           loop_end_pc,
  input  logic [PCW-1:0]           loop_start_pc,
  input  logic                     irq_take,
  input  logic [PCW-1:0]           irq_from_pc,
  input  logic [PCW-1:0]           irq_vector,
  output logic                     stall_req,
  input  logic                     rd_en,
  input  logic                     rd_flush,
  output logic                     rd_valid,
  output logic [2:0]               rd_tag,
  output logic [PCW-1:0]           rd_addr,
  output logic [$clog2(DEPTH):0]   buf_level,
  output logic                     wrapped
);
  localparam int BAW = $clog2(DEPTH);
  localparam int QAW = $clog2(QDEPTH);
  localparam int EW  = PCW + 3;
  localparam int B_COF = 0, B_INT = 1, B_EXEC = 2, B_MARK = 3, B_EN = 4, B_LOOP = 5;
  localparam logic [2:0] T_COF_SRC = 3'd0, T_COF_DST = 3'd1, T_INT_SRC = 3'd2,
                         T_INT_VEC = 3'd3, T_LOOP_LA = 3'd4, T_LOOP_SA = 3'd5,
                         T_MARK = 3'd6, T_EXEC = 3'd7;

  // control register
  logic [5:0] cfg, cfg_nx;
  always_comb begin
    cfg_nx = cfg_we ? cfg_wdata : cfg;
    if (trig_on)  cfg_nx[B_EN] = 1'b1;
    if (trig_off) cfg_nx[B_EN] = 1'b0;
  end
  always_ff @(posedge clk)
    if (!rst_n) cfg <= '0;
    else        cfg <= cfg_nx;
  assign cfg_q = cfg;

  // event selection: one event per cycle, fixed rank
  logic [QAW:0]  q_cnt;
  logic          accept;
  logic [1:0]    n_new;
  logic [EW-1:0] e0, e1;
  assign stall_req = q_cnt >= (QAW+1)'(QDEPTH-1);
  assign accept    = cfg[B_EN] && !stall_req;

  always_comb begin
    n_new = 2'd0;
    e0    = '0;
    e1    = '0;
    if (accept) begin
      if (irq_take && cfg[B_INT]) begin
        n_new = 2'd2; e0 = {T_INT_SRC, irq_from_pc}; e1 = {T_INT_VEC, irq_vector};
      end else if (set_has_cof && cfg[B_COF]) begin
        n_new = 2'd2; e0 = {T_COF_SRC, set_pc}; e1 = {T_COF_DST, cof_dest};
      end else if (loop_edge && cfg[B_LOOP] && loop_count > LCW'(1)) begin
        n_new = loop_long ? 2'd2 : 2'd1;
        e0 = {T_LOOP_LA, loop_end_pc}; e1 = {T_LOOP_SA, loop_start_pc};
      end else if (mark_hit && cfg[B_MARK]) begin
        n_new = 2'd1; e0 = {T_MARK, set_pc};
      end else if (set_issue && cfg[B_EXEC]) begin
        n_new = 2'd1; e0 = {T_EXEC, set_pc};
      end
    end
  end

  // staging queue
  logic [EW-1:0]  q_mem [QDEPTH];
  logic [QAW-1:0] q_rp, q_wp;
  logic           q_has, buf_we;
  logic [1:0]     n_push;
  logic [EW-1:0]  p0, buf_wd;
  assign q_has  = q_cnt != '0;
  assign buf_we = q_has || (n_new != 2'd0);
  assign buf_wd = q_has ? q_mem[q_rp] : e0;
  assign n_push = q_has ? n_new : ((n_new == 2'd2) ? 2'd1 : 2'd0);
  assign p0     = q_has ? e0 : e1;

  always_ff @(posedge clk) begin
    if (n_push != 2'd0) q_mem[q_wp] <= p0;
    if (n_push == 2'd2) q_mem[q_wp + QAW'(1)] <= e1;
  end
  always_ff @(posedge clk)
    if (!rst_n) begin
      q_rp <= '0; q_wp <= '0; q_cnt <= '0;
    end else begin
      q_wp  <= q_wp + QAW'(n_push);
      q_rp  <= q_rp + QAW'(q_has);
      q_cnt <= q_cnt + (QAW+1)'(n_push) - (QAW+1)'(q_has);
    end

  // circular trace memory
  logic [EW-1:0]  b_mem [DEPTH];
  logic [BAW-1:0] b_wp, b_rp;
  logic [BAW:0]   b_cnt;
  logic           wrap_q, b_full, do_rd, ovw;
  assign b_full = b_cnt == (BAW+1)'(DEPTH);
  assign do_rd  = rd_en && (b_cnt != '0);
  assign ovw    = buf_we && b_full && !do_rd;

  always_ff @(posedge clk)
    if (buf_we) b_mem[b_wp] <= buf_wd;

  always_ff @(posedge clk)
    if (!rst_n) begin
      b_wp <= '0; b_rp <= '0; b_cnt <= '0; wrap_q <= 1'b0;
    end else if (rd_flush) begin
      b_wp   <= b_wp + BAW'(buf_we);
      b_rp   <= b_wp + BAW'(buf_we);
      b_cnt  <= '0;
      wrap_q <= 1'b0;
    end else begin
      b_wp  <= b_wp + BAW'(buf_we);
      b_rp  <= b_rp + BAW'(do_rd || ovw);
      b_cnt <= b_cnt + (BAW+1)'(buf_we && !ovw) - (BAW+1)'(do_rd);
      if (ovw) wrap_q <= 1'b1;
    end

  assign rd_valid           = b_cnt != '0;
  assign {rd_tag, rd_addr}  = b_mem[b_rp];
  assign buf_level          = b_cnt;
  assign wrapped            = wrap_q;

  // assertions
  assert_trig_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_off |=> !cfg_q[B_EN]);
  assert_trig_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_on && !trig_off) |=> cfg_q[B_EN]);
  assert_no_capture_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[B_EN] && !q_has) |-> !buf_we);
  assert_queue_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= (QAW+1)'(QDEPTH));
  assert_stall_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |=> q_cnt == $past(q_cnt) - 1'b1);
  assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_level <= (BAW+1)'(DEPTH));
  assert_wrap_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrapped) |-> $past(buf_level) == (BAW+1)'(DEPTH));
  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flush |=> (buf_level == '0 && !wrapped));
  assert_pop_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_valid && !buf_we && !rd_flush) |=> buf_level == $past(buf_level) - 1'b1);
endmodule

// File: tb/flow_trace_unit_bench.sv
module flow_trace_unit_bench;
  localparam int PCW = 32, DEPTH = 8, QDEPTH = 4, LCW = 16, EW = PCW + 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cfg_we = 1'b0, trig_on = 1'b0, trig_off = 1'b0;
  logic [5:0] cfg_wdata = '0, cfg_q;
  logic set_issue = 0, set_has_cof = 0, mark_hit = 0, loop_edge = 0, loop_long = 0, irq_take = 0;
  logic [PCW-1:0] set_pc = '0, cof_dest = '0, loop_end_pc = '0, loop_start_pc = '0;
  logic [PCW-1:0] irq_from_pc = '0, irq_vector = '0, rd_addr;
  logic [LCW-1:0] loop_count = '0;
  logic stall_req, rd_en = 1'b0, rd_flush = 1'b0, rd_valid, wrapped;
  logic [2:0] rd_tag;
  logic [$clog2(DEPTH):0] buf_level;

  flow_trace_unit #(.PCW(PCW), .DEPTH(DEPTH), .QDEPTH(QDEPTH), .LCW(LCW)) u_flow_trace_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .trig_on(trig_on), .trig_off(trig_off), .set_issue(set_issue), .set_has_cof(set_has_cof),
    .mark_hit(mark_hit), .set_pc(set_pc), .cof_dest(cof_dest), .loop_edge(loop_edge),
    .loop_long(loop_long), .loop_count(loop_count), .loop_end_pc(loop_end_pc),
    .loop_start_pc(loop_start_pc), .irq_take(irq_take), .irq_from_pc(irq_from_pc),
    .irq_vector(irq_vector), .stall_req(stall_req), .rd_en(rd_en), .rd_flush(rd_flush),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_addr(rd_addr), .buf_level(buf_level),
    .wrapped(wrapped));

  int checks = 0, fails = 0;
  bit done = 0, drain = 0;
  string cur_req = "R1";
  logic [EW-1:0] exp_q [$];
  logic [EW-1:0] mon_e;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: pops trace entries and compares against the scoreboard queue
  always @(negedge clk) begin
    if (drain && rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s actual=%h expected=none", cur_req, {rd_tag, rd_addr});
      end else begin
        mon_e = exp_q.pop_front();
        if ({rd_tag, rd_addr} !== mon_e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", cur_req, {rd_tag, rd_addr}, mon_e);
        end
      end
      rd_en <= 1'b1;
    end else rd_en <= 1'b0;
  end

  task automatic step();
    @(negedge clk);
    set_issue = 0; set_has_cof = 0; mark_hit = 0; loop_edge = 0; irq_take = 0;
    trig_on = 0; trig_off = 0; cfg_we = 0; rd_flush = 0;
  endtask

  task automatic set_cfg(input logic [5:0] v);
    cfg_we = 1; cfg_wdata = v; step();
  endtask

  task automatic ev_cof(input logic [PCW-1:0] pc, dst, input bit ex);
    set_has_cof = 1; set_pc = pc; cof_dest = dst;
    if (ex) begin exp_q.push_back({3'd0, pc}); exp_q.push_back({3'd1, dst}); end
    step();
  endtask

  task automatic ev_irq(input logic [PCW-1:0] src, vec, input bit ex);
    irq_take = 1; irq_from_pc = src; irq_vector = vec;
    if (ex) begin exp_q.push_back({3'd2, src}); exp_q.push_back({3'd3, vec}); end
    step();
  endtask

  task automatic ev_loop(input logic [PCW-1:0] la, sa, input logic [LCW-1:0] cnt, input bit lng, on);
    loop_edge = 1; loop_end_pc = la; loop_start_pc = sa; loop_count = cnt; loop_long = lng;
    if (on && cnt > 1) begin
      exp_q.push_back({3'd4, la});
      if (lng) exp_q.push_back({3'd5, sa});
    end
    step();
  endtask

  task automatic ev_mark(input logic [PCW-1:0] pc, input bit ex);
    mark_hit = 1; set_pc = pc;
    if (ex) exp_q.push_back({3'd6, pc});
    step();
  endtask

  task automatic ev_exec(input logic [PCW-1:0] pc, input bit ex);
    set_issue = 1; set_pc = pc;
    if (ex) exp_q.push_back({3'd7, pc});
    step();
  endtask

  task automatic settle(input string req);
    repeat (24) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R12 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    step();
    chk(cfg_q == 6'h00, "R1", cfg_q, 0);
    chk(!rd_valid && buf_level == 0, "R12", {rd_valid, buf_level}, 0);
    chk(!stall_req && !wrapped, "R9", {stall_req, wrapped}, 0);

    set_cfg(6'h2d);
    chk(cfg_q == 6'h2d, "R1", cfg_q, 6'h2d);

    // R3: every mode on, global enable off
    cur_req = "R3"; drain = 1;
    set_cfg(6'h2f);
    ev_cof(32'h100, 32'h200, 0);
    ev_irq(32'h110, 32'h800, 0);
    ev_mark(32'h120, 0);
    ev_exec(32'h124, 0);
    ev_loop(32'h140, 32'h130, 16'd4, 1, 0);
    settle("R3");
    chk(buf_level == 0, "R3", buf_level, 0);

    // R2: hardware triggers
    trig_on = 1; step();
    chk(cfg_q == 6'h3f, "R2", cfg_q, 6'h3f);
    trig_off = 1; step();
    chk(cfg_q == 6'h2f, "R2", cfg_q, 6'h2f);
    trig_on = 1; trig_off = 1; step();
    chk(cfg_q[4] == 1'b0, "R2", cfg_q[4], 0);

    // R4: change of flow
    cur_req = "R4";
    set_cfg(6'h11);
    ev_cof(32'h1000, 32'h2000, 1);
    ev_cof(32'h1010, 32'h0000_4444, 1);
    ev_exec(32'h1014, 0);
    settle("R4");

    // R5: interrupts
    cur_req = "R5";
    set_cfg(6'h12);
    ev_irq(32'h3000, 32'hFFFF_0040, 1);
    ev_cof(32'h3004, 32'h3100, 0);
    settle("R5");

    // R6: loops
    cur_req = "R6";
    set_cfg(6'h30);
    ev_loop(32'h5020, 32'h5000, 16'd3, 1, 1);
    ev_loop(32'h5020, 32'h5000, 16'd2, 1, 1);
    ev_loop(32'h5020, 32'h5000, 16'd1, 1, 1);
    ev_loop(32'h6010, 32'h6000, 16'd5, 0, 1);
    ev_loop(32'h6010, 32'h6000, 16'd0, 1, 1);
    settle("R6");

    // R7: mark and execution-set tracing
    cur_req = "R7";
    set_cfg(6'h18);
    ev_mark(32'h7000, 1);
    ev_exec(32'h7004, 0);
    set_cfg(6'h14);
    ev_exec(32'h7100, 1);
    ev_exec(32'h7104, 1);
    ev_exec(32'h7108, 1);
    settle("R7");

    // R8: simultaneous strobes
    cur_req = "R8";
    set_cfg(6'h3f);
    irq_take = 1; irq_from_pc = 32'h8000; irq_vector = 32'h8800;
    set_has_cof = 1; cof_dest = 32'h8100; set_pc = 32'h8004;
    mark_hit = 1; set_issue = 1;
    loop_edge = 1; loop_count = 5; loop_long = 1; loop_end_pc = 32'h8200; loop_start_pc = 32'h8180;
    exp_q.push_back({3'd2, 32'h8000}); exp_q.push_back({3'd3, 32'h8800});
    step();
    set_has_cof = 1; set_pc = 32'h8010; cof_dest = 32'h8300; mark_hit = 1; set_issue = 1;
    exp_q.push_back({3'd0, 32'h8010}); exp_q.push_back({3'd1, 32'h8300});
    step();
    mark_hit = 1; set_issue = 1; set_pc = 32'h8020;
    exp_q.push_back({3'd6, 32'h8020});
    step();
    settle("R8");

    // R9: staging queue and stall
    cur_req = "R9"; drain = 0;
    set_cfg(6'h11);
    ev_cof(32'h9000, 32'h9100, 1);
    ev_cof(32'h9010, 32'h9110, 1);
    ev_cof(32'h9020, 32'h9120, 1);
    chk(stall_req == 1'b1, "R9", stall_req, 1);
    ev_cof(32'h9030, 32'h9130, 0);
    chk(stall_req == 1'b0, "R9", stall_req, 0);
    chk(buf_level == 4, "R9", buf_level, 4);
    drain = 1;
    settle("R9");

    // R10: overwrite when full
    cur_req = "R10"; drain = 0;
    set_cfg(6'h18);
    for (int i = 0; i < DEPTH; i++) ev_mark(32'hA000 + 32'(i * 4), 1);
    chk(buf_level == DEPTH && !wrapped, "R10", {buf_level, wrapped}, {5'(DEPTH), 1'b0});
    ev_mark(32'hA100, 1);
    ev_mark(32'hA104, 1);
    chk(buf_level == DEPTH, "R10", buf_level, DEPTH);
    chk(wrapped == 1'b1, "R10", wrapped, 1);
    exp_q.delete(0);
    exp_q.delete(0);
    drain = 1;
    settle("R10");
    chk(wrapped == 1'b1, "R10", wrapped, 1);

    // R11: flush
    cur_req = "R11"; drain = 0;
    ev_mark(32'hB000, 0);
    ev_mark(32'hB004, 0);
    chk(buf_level == 2, "R11", buf_level, 2);
    rd_flush = 1; step();
    chk(buf_level == 0 && !rd_valid && !wrapped, "R11", {buf_level, rd_valid, wrapped}, 0);
    drain = 1;
    ev_mark(32'hB100, 1);
    settle("R11");

    // R12: ordered readout after mixed traffic
    cur_req = "R12"; drain = 0;
    set_cfg(6'h1b);
    ev_mark(32'hC000, 1);
    ev_cof(32'hC004, 32'hC800, 1);
    ev_mark(32'hC008, 1);
    chk(rd_valid == 1'b1, "R12", rd_valid, 1);
    drain = 1;
    settle("R12");
    chk(!rd_valid, "R12", rd_valid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule